// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. On every clock edge while it is running, the value grows by a fixed nominal step (`STEP_NS`). A drift corrector trims the rate of the counter. It measures out a programmed interval, and when the interval expires it makes that edge's step a few nanoseconds longer or shorter. Software converts a frequency error into an interval, an amount and a sign, and packs them into one 32-bit configuration word.

A small register port controls the counter. Software can pause and resume counting, load either half of the time while the counter is paused, hold the drift unit in reset while it reprograms it, and read the time as two 32-bit words. Reading the low word captures the high word in a shadow register, so a read of the low word followed by a read of the high word returns one coherent 64-bit value.

Writes and reads are single-cycle strobes with no back-pressure. A write is taken on the edge where `wr_en` is high. A read is taken on the edge where `rd_en` is high, and its data is returned with `rvalid` on the following cycle. The port never stalls, so the caller needs no ready signal.

Register addresses:
- 0: control
- 1: load low
- 2: load high
- 3: time low
- 4: time high
- 5: drift reset
- 6: drift configuration

Top module: `drift_time_counter`

## Requirements
- R1: After reset the time is 0 and the counter is running. Address 0 reads 1 in bit 0 (running), address 5 (drift reset bit) reads 0, and address 6 (drift configuration) reads 0.
- R2: While running, with no correction firing, the time grows by `STEP_NS` (default 4) on every clock edge.
- R3: A write of value 2 to address 0 pauses the counter: the time holds and bit 0 of address 0 reads 0. A write of value 4 resumes it. A write of any other value to address 0 changes nothing.
- R4: A write to address 1 replaces time bits 31:0, and a write to address 2 replaces bits 63:32, but only while the counter is paused. While it runs, both writes are ignored.
- R5: A read of address 3 returns time bits 31:0 and copies bits 63:32 into a shadow register. A read of address 4 returns that shadow, even if the live high word has since carried.
- R6: The configuration word holds the interval I in bits 27:0, the amount A in bits 30:28 and the direction in bit 31. When bit 31 is 1, A ns is added to the step on the k-th running edge after a reload, where k is the smallest value with k·STEP_NS ≥ I·16+8.
- R7: When bit 31 is 0, the correction subtracts A ns from the step instead.
- R8: When A is 0 no correction is ever applied. This includes a configuration word of 0x0FFFFFFF (maximum interval) and an all-zero word.
- R9: Bit 0 of address 5 is the drift reset bit, and it reads back as written. A write to address 6 is accepted only while that bit is 1; otherwise it is ignored. Address 6 reads back the stored word.
- R10: The drift interval count advances only on running edges and keeps its progress across a pause. It restarts after every correction, and it is cleared while the drift reset bit is 1.
- R11: A read taken on an edge raises `rvalid` for exactly the next cycle, with the data on `rdata`. Addresses 1, 2 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with `rvalid` |
| rvalid | output | 1 | Read response strobe, one cycle after `rd_en` |

## Verification
The bench times each run segment by the edges its own writes land on, so it can predict the time exactly. It checks the shortest interval (I=0, which fires every second edge), subtraction that leaves a net step of less than the nominal one, and the case where a pause falls inside an interval. A design that reset its interval count on pause would show a missing correction. A design that ignored the drift reset would show an extra one.

A low-word read taken just before a carry, followed by a high-word read after the carry, exposes a design without a shadow: it would return the new high word. Loads issued while running, invalid control codes, and configuration writes made without the drift reset bit are each followed by a read-back. A design that let any of them through would show a changed time or a changed configuration word.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int REG_DW     = 32;
  localparam int ADDR_W     = 3;
  localparam int IVL_W      = 28;
  localparam int AMT_W      = 3;
  localparam int QUANTA_LG2 = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL      = 3'd0,
    A_LOAD_LO   = 3'd1,
    A_LOAD_HI   = 3'd2,
    A_TIME_LO   = 3'd3,
    A_TIME_HI   = 3'd4,
    A_DRIFT_RST = 3'd5,
    A_DRIFT_CFG = 3'd6
  } reg_addr_e;

  localparam logic [REG_DW-1:0] CMD_PAUSE  = 32'd2;
  localparam logic [REG_DW-1:0] CMD_RESUME = 32'd4;

  typedef struct packed {
    logic             add;
    logic [AMT_W-1:0] amt;
    logic [IVL_W-1:0] ivl;
  } drift_cfg_t;
endpackage

// File: rtl/tsc_regif.sv
module tsc_regif
  import tsc_pkg::*;
#(
  parameter int TIME_W = 2 * REG_DW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              running,
  input  logic [TIME_W-1:0] time_now,
  output logic              pause_req,
  output logic              resume_req,
  output logic              load_lo,
  output logic              load_hi,
  output logic              drift_rst,
  output drift_cfg_t        drift_cfg,
  output logic [REG_DW-1:0] rdata,
  output logic              rvalid
);
  localparam int HI_W = TIME_W - REG_DW;

  reg_addr_e         a;
  logic              drst_q;
  drift_cfg_t        cfg_q;
  logic [HI_W-1:0]   shadow_q;
  logic [REG_DW-1:0] rd_word, rdata_q;
  logic              rvalid_q;

  assign a          = reg_addr_e'(addr);
  assign pause_req  = wr_en && (a == A_CTRL) && (wdata == CMD_PAUSE);
  assign resume_req = wr_en && (a == A_CTRL) && (wdata == CMD_RESUME);
  assign load_lo    = wr_en && (a == A_LOAD_LO);
  assign load_hi    = wr_en && (a == A_LOAD_HI);

  // drift control: config is only writable while the drift unit is held
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drst_q <= 1'b0;
      cfg_q  <= '0;
    end else if (wr_en) begin
      if (a == A_DRIFT_RST) drst_q <= wdata[0];
      if (a == A_DRIFT_CFG && drst_q) cfg_q <= drift_cfg_t'(wdata);
    end
  end

  always_comb begin
    case (a)
      A_CTRL:      rd_word = REG_DW'(running);
      A_TIME_LO:   rd_word = time_now[REG_DW-1:0];
      A_TIME_HI:   rd_word = REG_DW'(shadow_q);
      A_DRIFT_RST: rd_word = REG_DW'(drst_q);
      A_DRIFT_CFG: rd_word = cfg_q;
      default:     rd_word = '0;
    endcase
  end

  // read path: registered response, low-word read captures the high word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
      shadow_q <= '0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_word;
      if (rd_en && a == A_TIME_LO) shadow_q <= time_now[TIME_W-1:REG_DW];
    end
  end

  assign drift_rst = drst_q;
  assign drift_cfg = cfg_q;
  assign rdata     = rdata_q;
  assign rvalid    = rvalid_q;
endmodule

// File: rtl/tsc_drift.sv
module tsc_drift
  import tsc_pkg::*;
#(
  parameter int STEP_NS = 4,
  parameter int TIME_W  = 2 * REG_DW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              running,
  input  logic              drift_rst,
  input  drift_cfg_t        cfg,
  output logic              fire,
  output logic [TIME_W-1:0] delta
);
  localparam int ACC_W  = IVL_W + QUANTA_LG2 + 1;
  localparam int HALF_Q = 1 << (QUANTA_LG2 - 1);

  logic [ACC_W-1:0]  acc_q, acc_next, target;
  logic              expire;
  logic [TIME_W-1:0] step_v, amt_v;

  // interval in ns: quanta * 16 + 8
  assign target   = (ACC_W'(cfg.ivl) << QUANTA_LG2) + ACC_W'(HALF_Q);
  assign acc_next = acc_q + ACC_W'(STEP_NS);
  assign expire   = running && !drift_rst && (acc_next >= target);
  assign fire     = expire && (cfg.amt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || drift_rst) acc_q <= '0;
    else if (running)        acc_q <= expire ? '0 : acc_next;
  end

  assign step_v = TIME_W'(STEP_NS);
  assign amt_v  = TIME_W'(cfg.amt);

  always_comb begin
    if (!fire)        delta = step_v;
    else if (cfg.add) delta = step_v + amt_v;
    else              delta = step_v - amt_v;
  end
endmodule

// File: rtl/tsc_clock.sv
module tsc_clock
  import tsc_pkg::*;
#(
  parameter int TIME_W = 2 * REG_DW
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pause_req,
  input  logic              resume_req,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic [REG_DW-1:0] wdata,
  input  logic [TIME_W-1:0] delta,
  output logic              running,
  output logic [TIME_W-1:0] time_now
);
  logic              run_q;
  logic [TIME_W-1:0] time_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b1;
      time_q <= '0;
    end else begin
      if (pause_req)       run_q <= 1'b0;
      else if (resume_req) run_q <= 1'b1;

      if (run_q) begin
        time_q <= time_q + delta;
      end else begin
        if (load_lo) time_q[REG_DW-1:0]      <= wdata;
        if (load_hi) time_q[TIME_W-1:REG_DW] <= wdata;
      end
    end
  end

  assign running  = run_q;
  assign time_now = time_q;
endmodule

// File: rtl/drift_time_counter.sv
module drift_time_counter
  import tsc_pkg::*;
#(
  parameter int STEP_NS = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  output logic              rvalid
);
  localparam int TIME_W = 2 * REG_DW;

  logic              pause_req, resume_req, load_lo, load_hi;
  logic              drift_rst, running, fire;
  drift_cfg_t        cfg;
  logic [TIME_W-1:0] time_now, delta;

  tsc_regif #(.TIME_W(TIME_W)) u_regif (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .running(running), .time_now(time_now),
    .pause_req(pause_req), .resume_req(resume_req),
    .load_lo(load_lo), .load_hi(load_hi),
    .drift_rst(drift_rst), .drift_cfg(cfg),
    .rdata(rdata), .rvalid(rvalid)
  );

  tsc_drift #(.STEP_NS(STEP_NS), .TIME_W(TIME_W)) u_drift (
    .clk(clk), .rst_n(rst_n), .running(running), .drift_rst(drift_rst),
    .cfg(cfg), .fire(fire), .delta(delta)
  );

  tsc_clock #(.TIME_W(TIME_W)) u_clock (
    .clk(clk), .rst_n(rst_n), .pause_req(pause_req), .resume_req(resume_req),
    .load_lo(load_lo), .load_hi(load_hi), .wdata(wdata), .delta(delta),
    .running(running), .time_now(time_now)
  );
endmodule

// File: rtl/drift_time_counter_chk.sv
module drift_time_counter_chk
  import tsc_pkg::*;
#(
  parameter int STEP_NS = 4
)(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rvalid,
  input logic              running,
  input logic              fire,
  input logic              drift_rst,
  input logic [REG_DW-1:0] cfg_word,
  input logic [63:0]       time_now
);
  logic load_wr;
  assign load_wr = wr_en && (addr == A_LOAD_LO || addr == A_LOAD_HI);

  // R2: nominal step when no correction fires
  p_nominal_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !fire) |=> time_now == $past(time_now) + 64'(STEP_NS));

  // R6: added correction
  p_add_corr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && fire && cfg_word[31]) |=>
      time_now == $past(time_now) + 64'(STEP_NS) + 64'($past(cfg_word[30:28])));

  // R7: subtracted correction
  p_sub_corr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && fire && !cfg_word[31]) |=>
      time_now == $past(time_now) + 64'(STEP_NS) - 64'($past(cfg_word[30:28])));

  // R3: paused time holds unless loaded
  p_paused_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !load_wr) |=> $stable(time_now));

  // R8: zero amount never fires
  p_zero_amt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[30:28] == 3'd0) |-> !fire);

  // R10: held drift unit never fires; restart after a correction (STEP_NS below 24)
  p_held_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drift_rst |-> !fire);
  p_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_word[27:0] != 28'd0) |=> !fire);

  // R9: configuration guarded by the drift reset bit
  p_cfg_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DRIFT_CFG && !drift_rst) |=> $stable(cfg_word));

  // R11: one-cycle read response
  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  p_no_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
endmodule

bind drift_time_counter drift_time_counter_chk #(.STEP_NS(STEP_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rvalid(rvalid), .running(running), .fire(fire), .drift_rst(drift_rst),
  .cfg_word(cfg), .time_now(time_now)
);

// File: tb/tb_drift_time_counter.sv
`timescale 1ns/1ps
module tb_drift_time_counter;
  localparam int STEP = 4;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_LLO = 3'd1, AD_LHI = 3'd2,
                         AD_TLO = 3'd3, AD_THI = 3'd4, AD_DRST = 3'd5,
                         AD_CFG = 3'd6, AD_NONE = 3'd7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;

  always #2 clk = ~clk;

  drift_time_counter #(.STEP_NS(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  typedef struct {
    logic [31:0] d;
    logic [31:0] m;
    string       tag;
  } exp_t;

  exp_t    exp_q[$];
  int      tests = 0, fails = 0;
  int      edge_cnt = 0, last_edge = 0;
  bit      done = 0;

  // bench-side model of the time and drift phase
  longint unsigned tmodel = 0;
  longint          phase = 0, cyc_per = 1;
  int              m_amt = 0;
  bit              m_add = 0;

  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard on every read response
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) begin
        check(0, "R11 unexpected rvalid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(((rdata ^ e.d) & e.m) == 32'd0, e.tag, rdata & e.m, e.d & e.m);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; last_edge = edge_cnt;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
    exp_t x;
    x.d = e; x.m = m; x.tag = tag;
    exp_q.push_back(x);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic chk_time(input string tag);
    rd(AD_TLO, tmodel[31:0], 32'hFFFF_FFFF, tag);
    rd(AD_THI, tmodel[63:32], 32'hFFFF_FFFF, tag);
  endtask

  task automatic advance(input int n);
    tmodel += 64'(STEP * n);
    if (m_amt != 0) begin
      longint total, f;
      total = phase + n;
      f     = total / cyc_per;
      phase = total % cyc_per;
      if (m_add) tmodel += 64'(f * m_amt);
      else       tmodel -= 64'(f * m_amt);
    end
  endtask

  task automatic run_seg(input int k);
    int e0;
    wr(AD_CTRL, 32'd4); e0 = last_edge;
    repeat (k) @(negedge clk);
    wr(AD_CTRL, 32'd2);
    advance(last_edge - e0);
  endtask

  task automatic drift_set(input logic [31:0] w, input string tag);
    longint tgt;
    wr(AD_DRST, 32'd1);
    rd(AD_DRST, 32'd1, 32'hFFFF_FFFF, tag);
    wr(AD_CFG, w);
    rd(AD_CFG, w, 32'hFFFF_FFFF, tag);
    wr(AD_DRST, 32'd0);
    m_add = w[31]; m_amt = int'(w[30:28]);
    tgt = longint'(w[27:0]) * 16 + 8;
    cyc_per = (tgt + STEP - 1) / STEP;
    phase = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int e_rel, e0;
    repeat (4) @(negedge clk);
    rst_n = 1; e_rel = edge_cnt;
    // R1: reset state
    rd(AD_CTRL, 32'd1, 32'hFFFF_FFFF, "R1 running after reset");
    rd(AD_DRST, 32'd0, 32'hFFFF_FFFF, "R1 drift reset bit");
    rd(AD_CFG,  32'd0, 32'hFFFF_FFFF, "R1 drift config");
    wr(AD_CTRL, 32'd2);
    tmodel = 64'(STEP * (last_edge - e_rel));
    chk_time("R1 time counts from zero");
    rd(AD_CTRL, 32'd0, 32'hFFFF_FFFF, "R3 paused status");

    // R4: load while paused; R3: hold
    wr(AD_LLO, 32'h1234_5678);
    wr(AD_LHI, 32'h0000_000A);
    tmodel = 64'h0000_000A_1234_5678;
    chk_time("R4 load while paused");
    repeat (20) @(negedge clk);
    chk_time("R3 paused time holds");
    wr(AD_CTRL, 32'd3);
    rd(AD_CTRL, 32'd0, 32'hFFFF_FFFF, "R3 invalid code ignored");
    chk_time("R3 invalid code keeps time");

    // R2: nominal step
    run_seg(20);
    chk_time("R2 nominal step");

    // R4: loads while running are ignored
    wr(AD_CTRL, 32'd4); e0 = last_edge;
    rd(AD_CTRL, 32'd1, 32'hFFFF_FFFF, "R3 resume code");
    wr(AD_LLO, 32'd0);
    wr(AD_LHI, 32'd0);
    wr(AD_CTRL, 32'd2);
    advance(last_edge - e0);
    chk_time("R4 running load ignored");

    // R6: add 3 ns every 24 ns
    drift_set(32'hB000_0001, "R9 readback");
    run_seg(28);
    chk_time("R6 add correction");

    // R7: subtract 5 ns every 8 ns (shortest interval)
    drift_set(32'h5000_0000, "R9 readback");
    run_seg(15);
    chk_time("R7 subtract correction");

    // R10: progress kept across pause, cleared by drift reset
    drift_set(32'hF000_0001, "R9 readback");
    run_seg(1);
    run_seg(1);
    chk_time("R10 progress across pause");
    run_seg(2);
    drift_set(32'hF000_0001, "R9 readback");
    run_seg(1);
    chk_time("R10 cleared by drift reset");

    // R8: zero amount
    drift_set(32'h0FFF_FFFF, "R8 readback");
    run_seg(30);
    chk_time("R8 max interval no correction");
    drift_set(32'h0000_0000, "R8 readback");
    run_seg(10);
    chk_time("R8 zero word no correction");

    // R9: config write without drift reset is ignored
    wr(AD_CFG, 32'hF000_0000);
    rd(AD_CFG, 32'd0, 32'hFFFF_FFFF, "R9 guarded config write");
    run_seg(10);
    chk_time("R9 guarded write no effect");

    // R5: shadow keeps the high word across a carry
    wr(AD_LLO, 32'hFFFF_FF00);
    wr(AD_LHI, 32'd5);
    tmodel = 64'h0000_0005_FFFF_FF00;
    wr(AD_CTRL, 32'd4); e0 = last_edge;
    rd(AD_TLO, 32'd0, 32'd0, "R5 low read");
    repeat (100) @(negedge clk);
    rd(AD_THI, 32'd5, 32'hFFFF_FFFF, "R5 shadow after carry");
    rd(AD_TLO, 32'd0, 32'd0, "R5 second low read");
    rd(AD_THI, 32'd6, 32'hFFFF_FFFF, "R5 shadow updated");
    wr(AD_CTRL, 32'd2);
    advance(last_edge - e0);
    chk_time("R5 carry into high word");

    // R11: response timing and unused addresses
    rd(AD_NONE, 32'd0, 32'hFFFF_FFFF, "R11 unused address reads 0");
    rd(AD_LLO,  32'd0, 32'hFFFF_FFFF, "R11 load address reads 0");
    @(negedge clk); rd_en = 1; addr = AD_DRST;
    exp_q.push_back('{32'd0, 32'hFFFF_FFFF, "R11 drift reset read"});
    @(negedge clk); rd_en = 0;
    check(rvalid == 1'b1, "R11 rvalid one cycle after read", rvalid, 1);
    @(negedge clk);
    check(rvalid == 1'b0, "R11 rvalid lasts one cycle", rvalid, 0);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule